// File: doc/BRIEF.md
# DMA Bus Handshake Sequencer

This block times every transfer of a four-channel DMA controller. An arbiter outside the block picks one unmasked channel and presents it as a granted request. The sequencer then asks the processor for the bus with a hold request. Once hold acknowledge comes back, it owns the bus. It places the transfer address on the bus, strobes the upper address byte into an external latch, and runs the device acknowledge together with one read/write strobe pair. After each transfer it steps the channel's current address and count, then either keeps the bus or hands it back, depending on the channel's mode.

Each channel keeps a base and a current copy of its address and count. A write on the programming port loads both copies. Terminal count is signalled by pulling the end-of-process line low. If something outside pulls that line low during a transfer, the block in progress is suspended. A later grant resumes it from where it stopped. When a channel's auto-initialise bit is set, terminal count restores the current copies from the base copies.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, every bus output is low (hold_req, aen, adstb, dbus_oe, dack, the four strobes, eop_pull). A granted request seen while idle raises hold_req in the following cycle.
- R2: hold_req stays high and aen stays low for as many cycles as hold_ack is held low.
- R3: The first cycle after hold_ack is seen is an address phase with these outputs: aen=1, adstb=1 for that single cycle, addr_lo = current address bits [7:0], dbus_out = bits [15:8] with dbus_oe=1, and dack all zero.
- R4: The cycle after an address phase is a transfer cycle with these outputs: dack bit n=1 for the active channel n only, and addr_lo unchanged. If the channel's cfg_to_mem bit is 1, io_rd and mem_wr are high. If it is 0, mem_rd and io_wr are high.
- R5: After each transfer, the current address moves by one. It increments when the channel's cfg_dec bit is 0 and decrements when it is 1.
- R6: The count holds the number of transfers minus one. eop_pull is high during the transfer cycle in which the count is zero, and at no other time.
- R7: In single mode (cfg_block bit 0), hold_req and aen go low in the cycle after every transfer. Another transfer starts only after the request is sampled again while idle.
- R8: In block mode (cfg_block bit 1), a new address phase follows each transfer directly, with hold_req kept high, until the transfer that reaches terminal count. hold_req drops in the cycle after that transfer.
- R9: If eop_in_n is low during a transfer cycle, that transfer completes, then the bus is released and eop_pull stays low. The next grant continues from the updated address.
- R10: When the channel's cfg_auto bit is set, terminal count reloads the current address and count from the base copies. When it is clear, the address keeps stepping past terminal count.
- R11: After releasing the bus, the block stays released and ignores requests until hold_ack is low. It then returns to idle.
- R12: When prog_we is high, prog_addr and prog_cnt are written into both the base and the current copies of channel prog_chan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write base and current address/count |
| prog_chan | input | 2 | Channel written by prog_we |
| prog_addr | input | 16 | Start address to load |
| prog_cnt | input | 16 | Transfer count minus one to load |
| cfg_dec | input | 4 | Per channel: 1 = decrement address |
| cfg_block | input | 4 | Per channel: 1 = block mode, 0 = single mode |
| cfg_auto | input | 4 | Per channel: reload at terminal count |
| cfg_to_mem | input | 4 | Per channel: 1 = device to memory, 0 = memory to device |
| req_valid | input | 1 | Granted request from the arbiter |
| req_chan | input | 2 | Channel of the granted request |
| hold_ack | input | 1 | Bus grant from the processor |
| eop_in_n | input | 1 | Sensed end-of-process line, active low |
| hold_req | output | 1 | Bus request to the processor |
| aen | output | 1 | Address enable, the sequencer owns the bus |
| adstb | output | 1 | Upper address byte latch strobe |
| addr_lo | output | 8 | Low address byte |
| dbus_out | output | 8 | Data bus drive: upper address byte |
| dbus_oe | output | 1 | Data bus output enable |
| dack | output | 4 | Device acknowledge, one bit per channel |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| eop_pull | output | 1 | Pull the end-of-process line low |

## Verification
The checker assumes that the processor side follows the hold protocol. hold_ack rises only while hold_req is high and falls only after hold_req has dropped. It also assumes that req_chan stays stable while req_valid is high, and that no programming write targets a channel during its transfer. The bench drives hold_ack only in answer to a sampled hold_req, and removes it only once the release has been observed. It performs all programming writes before any request is raised, and it changes req_chan only while the sequencer is idle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQW,
        ST_ADDR,
        ST_XFER,
        ST_REL
    } seq_state_t;

    typedef struct packed {
        logic dec;
        logic block;
        logic auto_init;
        logic to_mem;
    } chan_mode_t;

    function automatic logic [15:0] step_addr16(input logic [15:0] a, input logic dec);
        return dec ? a - 16'd1 : a + 16'd1;
    endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       hold_ack,
    input  logic       is_block,
    input  logic       last,
    input  logic       eop_ext,
    output seq_state_t state,
    output logic       grab,
    output logic       advance
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_REQW;
            ST_REQW: if (hold_ack)  nxt = ST_ADDR;
            ST_ADDR: nxt = ST_XFER;
            ST_XFER: nxt = (last || !is_block || eop_ext) ? ST_REL : ST_ADDR;
            ST_REL:  if (!hold_ack) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign grab    = (state == ST_IDLE) && req_valid;
    assign advance = (state == ST_XFER);
endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           prog_we,
    input  logic [CHW-1:0] prog_chan,
    input  logic [AW-1:0]  prog_addr,
    input  logic [CW-1:0]  prog_cnt,
    input  logic           advance,
    input  logic [CHW-1:0] act_chan,
    input  logic           dec,
    input  logic           auto_init,
    output logic [AW-1:0]  act_addr,
    output logic           act_last
);
    logic [AW-1:0] base_a [NCH];
    logic [AW-1:0] cur_a  [NCH];
    logic [CW-1:0] base_c [NCH];
    logic [CW-1:0] cur_c  [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                base_a[g] <= '0;
                cur_a[g]  <= '0;
                base_c[g] <= '0;
                cur_c[g]  <= '0;
            end else if (prog_we && prog_chan == CHW'(g)) begin
                base_a[g] <= prog_addr;
                cur_a[g]  <= prog_addr;
                base_c[g] <= prog_cnt;
                cur_c[g]  <= prog_cnt;
            end else if (advance && act_chan == CHW'(g)) begin
                if (cur_c[g] == '0 && auto_init) begin
                    cur_a[g] <= base_a[g];
                    cur_c[g] <= base_c[g];
                end else begin
                    cur_a[g] <= dec ? cur_a[g] - AW'(1) : cur_a[g] + AW'(1);
                    cur_c[g] <= cur_c[g] - CW'(1);
                end
            end
        end
    end

    assign act_addr = cur_a[act_chan];
    assign act_last = (cur_c[act_chan] == '0);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CHW = $clog2(NCH),
    localparam int LOW = 8,
    localparam int HW  = AW - LOW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           prog_we,
    input  logic [CHW-1:0] prog_chan,
    input  logic [AW-1:0]  prog_addr,
    input  logic [CW-1:0]  prog_cnt,
    input  logic [NCH-1:0] cfg_dec,
    input  logic [NCH-1:0] cfg_block,
    input  logic [NCH-1:0] cfg_auto,
    input  logic [NCH-1:0] cfg_to_mem,
    input  logic           req_valid,
    input  logic [CHW-1:0] req_chan,
    input  logic           hold_ack,
    input  logic           eop_in_n,
    output logic           hold_req,
    output logic           aen,
    output logic           adstb,
    output logic [LOW-1:0] addr_lo,
    output logic [HW-1:0]  dbus_out,
    output logic           dbus_oe,
    output logic [NCH-1:0] dack,
    output logic           io_rd,
    output logic           io_wr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           eop_pull
);
    seq_state_t     state;
    logic           grab, advance, act_last;
    logic [CHW-1:0] act_chan;
    logic [AW-1:0]  act_addr;
    chan_mode_t     mode;

    always_ff @(posedge clk) begin
        if (rst)       act_chan <= '0;
        else if (grab) act_chan <= req_chan;
    end

    assign mode = '{dec:       cfg_dec[act_chan],
                    block:     cfg_block[act_chan],
                    auto_init: cfg_auto[act_chan],
                    to_mem:    cfg_to_mem[act_chan]};

    dma_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .hold_ack (hold_ack),
        .is_block (mode.block),
        .last     (act_last),
        .eop_ext  (!eop_in_n),
        .state    (state),
        .grab     (grab),
        .advance  (advance)
    );

    dma_seq_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .prog_we  (prog_we),
        .prog_chan(prog_chan),
        .prog_addr(prog_addr),
        .prog_cnt (prog_cnt),
        .advance  (advance),
        .act_chan (act_chan),
        .dec      (mode.dec),
        .auto_init(mode.auto_init),
        .act_addr (act_addr),
        .act_last (act_last)
    );

    logic in_addr, in_xfer;
    assign in_addr = (state == ST_ADDR);
    assign in_xfer = (state == ST_XFER);

    assign hold_req = (state == ST_REQW) || in_addr || in_xfer;
    assign aen      = in_addr || in_xfer;
    assign adstb    = in_addr;
    assign addr_lo  = aen ? act_addr[LOW-1:0] : '0;
    assign dbus_out = in_addr ? act_addr[AW-1:LOW] : '0;
    assign dbus_oe  = in_addr;
    assign dack     = in_xfer ? (NCH'(1) << act_chan) : '0;
    assign io_rd    = in_xfer && mode.to_mem;
    assign mem_wr   = in_xfer && mode.to_mem;
    assign mem_rd   = in_xfer && !mode.to_mem;
    assign io_wr    = in_xfer && !mode.to_mem;
    assign eop_pull = in_xfer && act_last;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           hold_req,
    input logic           hold_ack,
    input logic           aen,
    input logic           adstb,
    input logic           dbus_oe,
    input logic [NCH-1:0] dack,
    input logic           io_rd,
    input logic           io_wr,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           eop_pull
);
    assert_aen_after_ack_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(aen) |-> $past(hold_ack) && $past(hold_req));

    assert_bus_owned_R2: assert property (@(posedge clk) disable iff (rst)
        aen |-> hold_req);

    assert_adstb_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        adstb |=> !adstb);

    assert_adstb_on_aen_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(aen) |-> adstb && dbus_oe);

    assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    assert_strobe_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> (io_rd == mem_wr) && (io_wr == mem_rd) && (io_rd != io_wr));

    assert_no_stray_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (io_rd || io_wr || mem_rd || mem_wr) |-> (|dack));

    assert_eop_in_xfer_R6: assert property (@(posedge clk) disable iff (rst)
        eop_pull |-> (|dack));

    assert_eop_then_release_R8: assert property (@(posedge clk) disable iff (rst)
        eop_pull |=> !hold_req);

    assert_release_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_req) |-> !aen && (dack == '0));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [1:0]  prog_chan = '0;
    logic [15:0] prog_addr = '0;
    logic [15:0] prog_cnt = '0;
    logic [3:0]  cfg_dec    = 4'b0010;
    logic [3:0]  cfg_block  = 4'b0110;
    logic [3:0]  cfg_auto   = 4'b0010;
    logic [3:0]  cfg_to_mem = 4'b0101;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic        hold_ack = 1'b0;
    logic        eop_in_n = 1'b1;
    logic        hold_req, aen, adstb, dbus_oe;
    logic [7:0]  addr_lo, dbus_out;
    logic [3:0]  dack;
    logic        io_rd, io_wr, mem_rd, mem_wr, eop_pull;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    dma_xfer_seq u_dut (.*);

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic prog(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c);
        prog_we = 1'b1; prog_chan = ch; prog_addr = a; prog_cnt = c;
        tick;
        prog_we = 1'b0;
    endtask

    task automatic start(input logic [1:0] ch, input int waits);
        req_valid = 1'b1; req_chan = ch;
        tick;
        chk("R1 hold_req raised", hold_req, 1);
        for (int i = 0; i < waits; i++) begin
            tick;
            chk("R2 hold_req held", hold_req, 1);
            chk("R2 aen low while waiting", aen, 0);
        end
        hold_ack = 1'b1;
        tick;
    endtask

    task automatic addr_phase(input logic [15:0] a);
        chk("R3 aen", aen, 1);
        chk("R3 adstb", adstb, 1);
        chk("R3 addr_lo", addr_lo, a[7:0]);
        chk("R3 dbus_out", dbus_out, a[15:8]);
        chk("R3 dbus_oe", dbus_oe, 1);
        chk("R3 dack idle", dack, 0);
        tick;
    endtask

    task automatic xfer_phase(input logic [1:0] ch, input logic tomem, input logic [15:0] a,
                              input logic exp_eop, input logic ext);
        chk("R4 dack", dack, 32'(4'b0001 << ch));
        chk("R4 io_rd", io_rd, tomem);
        chk("R4 mem_wr", mem_wr, tomem);
        chk("R4 mem_rd", mem_rd, !tomem);
        chk("R4 io_wr", io_wr, !tomem);
        chk("R4 addr_lo", addr_lo, a[7:0]);
        chk("R3 adstb one cycle", adstb, 0);
        chk("R6 eop_pull", eop_pull, exp_eop);
        eop_in_n = !ext;
        tick;
        eop_in_n = 1'b1;
    endtask

    task automatic release_bus(input string req);
        chk({req, " hold_req dropped"}, hold_req, 0);
        chk({req, " aen dropped"}, aen, 0);
        tick;
        chk("R11 stays released while ack high", hold_req, 0);
        chk("R11 no bus while ack high", aen, 0);
        hold_ack = 1'b0;
        req_valid = 1'b0;
        tick;
        tick;
        chk("R11 idle after ack low", hold_req, 0);
    endtask

    task automatic t_reset;
        repeat (3) tick;
        rst = 1'b0;
        tick;
        chk("R1 reset hold_req", hold_req, 0);
        chk("R1 reset aen", aen, 0);
        chk("R1 reset dack", dack, 0);
        chk("R1 reset strobes", {io_rd, io_wr, mem_rd, mem_wr, eop_pull, dbus_oe, adstb}, 0);
    endtask

    task automatic t_program;
        prog(2'd0, 16'h1234, 16'd2);   // R12
        prog(2'd1, 16'h0A00, 16'd2);
        prog(2'd2, 16'h00FF, 16'd5);
    endtask

    task automatic t_single;
        start(0, 0);
        addr_phase(16'h1234);           // R12 loaded value
        xfer_phase(0, 1, 16'h1234, 0, 0);
        release_bus("R7");
        start(0, 0);
        addr_phase(16'h1235);           // R5 increment
        xfer_phase(0, 1, 16'h1235, 0, 0);
        release_bus("R7");
        start(0, 0);
        addr_phase(16'h1236);
        xfer_phase(0, 1, 16'h1236, 1, 0);  // R6 terminal count
        release_bus("R7");
        start(0, 0);
        addr_phase(16'h1237);           // R10 no reload without auto
        xfer_phase(0, 1, 16'h1237, 0, 0);
        release_bus("R7");
    endtask

    task automatic t_block_auto;
        start(1, 3);
        addr_phase(16'h0A00);
        xfer_phase(1, 0, 16'h0A00, 0, 0);
        chk("R8 hold kept", hold_req, 1);
        addr_phase(16'h09FF);           // R5 decrement
        xfer_phase(1, 0, 16'h09FF, 0, 0);
        chk("R8 hold kept", hold_req, 1);
        addr_phase(16'h09FE);
        xfer_phase(1, 0, 16'h09FE, 1, 0);
        release_bus("R8");
        start(1, 0);
        addr_phase(16'h0A00);           // R10 auto reload
        xfer_phase(1, 0, 16'h0A00, 0, 1);
        chk("R9 no eop_pull on external end", eop_pull, 0);
        release_bus("R9");
    endtask

    task automatic t_ext_eop;
        start(2, 0);
        addr_phase(16'h00FF);
        xfer_phase(2, 1, 16'h00FF, 0, 0);
        addr_phase(16'h0100);
        xfer_phase(2, 1, 16'h0100, 0, 1);
        release_bus("R9");
        start(2, 0);
        addr_phase(16'h0101);           // R9 resumes
        xfer_phase(2, 1, 16'h0101, 0, 1);
        release_bus("R9");
    endtask

    initial begin
        t_reset;
        t_program;
        t_single;
        t_block_auto;
        t_ext_eop;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog R1 act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule